// File: doc/BRIEF.md
# Banked Data Memory Front End

This block sits between an 8-bit microcontroller core and its data storage. Every 8-bit data address is resolved here. The low quarter (00H–3FH) is one shared register space that every bank sees. The upper part (40H–FFH) is general-purpose RAM, and it is replicated once per bank. Three registers live in the shared space: two 8-bit memory pointers and a bank pointer. The bank pointer is held at address 04H.

Two addresses hold no storage. An access to 00H is redirected to the byte named by the first pointer, and that access always goes to bank 0. An access to 02H is redirected to the byte named by the second pointer, and that access goes to the bank in the bank pointer. An indirect access whose target is itself one of these two addresses reads zero and writes nothing. Any target below 40H resolves in the shared space, so the bank pointer has no effect there. The number of implemented banks is a parameter. A bank number at or above that count reads zero and discards writes. Reads are combinational from the address. Writes land on the rising clock edge.

Top module: `dmem_banked_front`

## Requirements
- R1: While rst_ni is low, both memory pointers and the bank pointer hold zero, and the pointer outputs show zero.
- R2: A read of 00H returns the byte addressed by the first pointer (address 01H) in bank 0, whatever the bank pointer holds. A write to 00H stores into that same byte.
- R3: A read or write of 02H accesses the byte addressed by the second pointer (address 03H) in the bank selected by the bank pointer.
- R4: If the pointer used by an indirect access holds 00H or 02H, the read returns 00H and the write changes no state.
- R5: The bank pointer at 04H is BP_W bits wide (default 5). A write keeps only bits [BP_W-1:0], and on a read the upper bits come back as 0.
- R6: A direct access to 40H–FFH reaches the bank selected by the bank pointer. Each bank holds separate contents.
- R7: A direct or indirect access to 00H–3FH reaches the shared space, whatever the bank pointer holds.
- R8: When the selected bank number is NUM_BANKS or greater (default 4), a read of 40H–FFH returns 00H and a write changes no implemented bank.
- R9: rdata_o follows addr_i combinationally while rd_i is high and is 00H while rd_i is low. A write with wr_i high takes effect at the next rising clk_i edge.
- R10: The first pointer is at 01H, the second at 03H and the bank pointer at 04H. All three can be read and written directly, and they also appear on mp0_o, mp1_o and bp_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes occur on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Data address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| mp0_o | output | 8 | First memory pointer |
| mp1_o | output | 8 | Second memory pointer |
| bp_o | output | BP_W | Bank pointer |

## Verification
A read result shows up in the same cycle as its address, with no register in between. The bench drives each vector just after a falling edge and samples rdata_o 2 ns later, which is before the next rising edge. A write takes effect at that rising edge. For that reason the effect of every write is checked by a later vector, never by the vector that did the write. The pointer outputs change one edge after their write, and the bench samples them in a later low phase. Checks that some access was ignored read back the state it could have changed, through a direct or indirect read.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] IND0_ADDR = 8'h00;
  localparam logic [ADDR_W-1:0] MP0_ADDR  = 8'h01;
  localparam logic [ADDR_W-1:0] IND1_ADDR = 8'h02;
  localparam logic [ADDR_W-1:0] MP1_ADDR  = 8'h03;
  localparam logic [ADDR_W-1:0] BP_ADDR   = 8'h04;
  localparam logic [ADDR_W-1:0] BANK_BASE = 8'h40;
  localparam int SHARED_DEPTH = 64;
  localparam int SHARED_AW    = $clog2(SHARED_DEPTH);
  localparam int BANK_DEPTH   = (1 << ADDR_W) - SHARED_DEPTH;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_PTR,
    TGT_SHARED,
    TGT_BANK
  } tgt_e;
endpackage

// File: rtl/dmem_addr_decode.sv
module dmem_addr_decode
  import dmem_pkg::*;
#(
  parameter int BP_W      = 5,
  parameter int NUM_BANKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] mp0_i,
  input  logic [ADDR_W-1:0] mp1_i,
  input  logic [BP_W-1:0]   bp_i,
  output tgt_e              tgt_o,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [BP_W-1:0]   bank_o,
  output logic              self_ref_o
);
  logic ind0, ind1;

  always_comb begin
    ind0       = (addr_i == IND0_ADDR);
    ind1       = (addr_i == IND1_ADDR);
    eff_addr_o = ind0 ? mp0_i : (ind1 ? mp1_i : addr_i);
    bank_o     = ind0 ? '0 : bp_i;
    self_ref_o = (ind0 || ind1) &&
                 (eff_addr_o == IND0_ADDR || eff_addr_o == IND1_ADDR);
    if (self_ref_o)
      tgt_o = TGT_NONE;
    else if (eff_addr_o < BANK_BASE)
      tgt_o = (eff_addr_o == MP0_ADDR || eff_addr_o == MP1_ADDR ||
               eff_addr_o == BP_ADDR) ? TGT_PTR : TGT_SHARED;
    else if (32'(bank_o) < NUM_BANKS)
      tgt_o = TGT_BANK;
    else
      tgt_o = TGT_NONE;
  end

  // first pointer never leaves bank 0
  p_mp0_bank0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IND0_ADDR && tgt_o == TGT_BANK) |-> bank_o == '0);

  // low region resolves to shared space regardless of bank pointer
  p_low_shared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!self_ref_o && eff_addr_o < BANK_BASE) |-> (tgt_o == TGT_PTR || tgt_o == TGT_SHARED));
endmodule

// File: rtl/dmem_ptr_regs.sv
module dmem_ptr_regs
  import dmem_pkg::*;
#(
  parameter int BP_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] mp0_o,
  output logic [ADDR_W-1:0] mp1_o,
  output logic [BP_W-1:0]   bp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mp0_o <= '0;
      mp1_o <= '0;
      bp_o  <= '0;
    end else if (we_i) begin
      if (addr_i == MP0_ADDR) mp0_o <= wdata_i;
      if (addr_i == MP1_ADDR) mp1_o <= wdata_i;
      if (addr_i == BP_ADDR)  bp_o  <= wdata_i[BP_W-1:0];
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni)
      p_reset_clear_r1: assert (mp0_o == '0 && mp1_o == '0 && bp_o == '0);
  end

  p_bp_trunc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == BP_ADDR) |=> bp_o == $past(wdata_i[BP_W-1:0]));
endmodule

// File: rtl/dmem_shared_ram.sv
module dmem_shared_ram
  import dmem_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [SHARED_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] mem_q [SHARED_DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/dmem_bank_ram.sv
module dmem_bank_ram
  import dmem_pkg::*;
#(
  parameter int BP_W      = 5,
  parameter int NUM_BANKS = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [BP_W-1:0]   bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int OFS_W = $clog2(BANK_DEPTH);

  logic [OFS_W-1:0]  ofs;
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];

  assign ofs = OFS_W'(addr_i - BANK_BASE);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [DATA_W-1:0] mem_q [BANK_DEPTH];
    logic              hit;
    assign hit = (32'(bank_i) == g);
    always_ff @(posedge clk_i) begin
      if (we_i && hit) mem_q[ofs] <= wdata_i;
    end
    assign bank_rd[g] = mem_q[ofs];
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (32'(bank_i) == b) rdata_o = bank_rd[b];
  end
endmodule

// File: rtl/dmem_banked_front.sv
module dmem_banked_front
  import dmem_pkg::*;
#(
  parameter int BP_W      = 5,
  parameter int NUM_BANKS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      addr_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  output logic [7:0]      mp0_o,
  output logic [7:0]      mp1_o,
  output logic [BP_W-1:0] bp_o
);
  tgt_e              tgt;
  logic [ADDR_W-1:0] eff_addr;
  logic [BP_W-1:0]   bank;
  logic              self_ref;
  logic [DATA_W-1:0] shared_rd, bank_rd, ptr_rd;

  dmem_addr_decode #(.BP_W(BP_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .clk_i, .rst_ni, .addr_i,
    .mp0_i(mp0_o), .mp1_i(mp1_o), .bp_i(bp_o),
    .tgt_o(tgt), .eff_addr_o(eff_addr), .bank_o(bank), .self_ref_o(self_ref)
  );

  dmem_ptr_regs #(.BP_W(BP_W)) u_ptr (
    .clk_i, .rst_ni,
    .we_i(wr_i && tgt == TGT_PTR), .addr_i(eff_addr), .wdata_i,
    .mp0_o, .mp1_o, .bp_o
  );

  dmem_shared_ram u_shared (
    .clk_i,
    .we_i(wr_i && tgt == TGT_SHARED), .addr_i(eff_addr[SHARED_AW-1:0]),
    .wdata_i, .rdata_o(shared_rd)
  );

  dmem_bank_ram #(.BP_W(BP_W), .NUM_BANKS(NUM_BANKS)) u_bank (
    .clk_i,
    .we_i(wr_i && tgt == TGT_BANK), .bank_i(bank), .addr_i(eff_addr),
    .wdata_i, .rdata_o(bank_rd)
  );

  always_comb begin
    unique case (eff_addr)
      MP0_ADDR: ptr_rd = mp0_o;
      MP1_ADDR: ptr_rd = mp1_o;
      default:  ptr_rd = DATA_W'(bp_o);
    endcase
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (tgt)
        TGT_PTR:    rdata_o = ptr_rd;
        TGT_SHARED: rdata_o = shared_rd;
        TGT_BANK:   rdata_o = bank_rd;
        default:    rdata_o = '0;
      endcase
    end
  end

  p_self_ref_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && self_ref) |=> ($stable(mp0_o) && $stable(mp1_o) && $stable(bp_o)));

  p_self_ref_rd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && self_ref) |-> rdata_o == '0);

  p_unimpl_rd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && eff_addr >= BANK_BASE && 32'(bank) >= NUM_BANKS) |-> rdata_o == '0);

  p_idle_rd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

// File: tb/tb_dmem_banked_front.sv
module tb_dmem_banked_front;
  localparam int BP_W = 5;
  localparam int NUM_BANKS = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [7:0]      addr_i = '0;
  logic            rd_i = 1'b0;
  logic            wr_i = 1'b0;
  logic [7:0]      wdata_i = '0;
  logic [7:0]      rdata_o, mp0_o, mp1_o;
  logic [BP_W-1:0] bp_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  dmem_banked_front #(.BP_W(BP_W), .NUM_BANKS(NUM_BANKS)) dut (.*);

  always #4 clk_i = ~clk_i;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [7:0] addr;
    logic [7:0] wd;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'h04, 8'h01, 8'h00, 8'd10}, // R10 BP=1
    '{1'b0, 1'b1, 8'h04, 8'h00, 8'h01, 8'd10}, // R10
    '{1'b1, 1'b0, 8'h40, 8'hA1, 8'h00, 8'd6},  // R6 bank1[40]
    '{1'b1, 1'b0, 8'h04, 8'h00, 8'h00, 8'd10},
    '{1'b1, 1'b0, 8'h40, 8'hB0, 8'h00, 8'd6},  // R6 bank0[40]
    '{1'b0, 1'b1, 8'h40, 8'h00, 8'hB0, 8'd6},
    '{1'b1, 1'b0, 8'h04, 8'h01, 8'h00, 8'd10},
    '{1'b0, 1'b1, 8'h40, 8'h00, 8'hA1, 8'd6},  // R6 separate banks
    '{1'b1, 1'b0, 8'h01, 8'h50, 8'h00, 8'd10}, // MP0=50
    '{1'b0, 1'b1, 8'h01, 8'h00, 8'h50, 8'd10},
    '{1'b1, 1'b0, 8'h00, 8'hC3, 8'h00, 8'd2},  // R2 bank0[50] with BP=1
    '{1'b0, 1'b1, 8'h00, 8'h00, 8'hC3, 8'd2},
    '{1'b1, 1'b0, 8'h04, 8'h00, 8'h00, 8'd10},
    '{1'b0, 1'b1, 8'h50, 8'h00, 8'hC3, 8'd2},  // R2 landed in bank0
    '{1'b1, 1'b0, 8'h03, 8'h60, 8'h00, 8'd10}, // MP1=60
    '{1'b1, 1'b0, 8'h04, 8'h01, 8'h00, 8'd10},
    '{1'b1, 1'b0, 8'h02, 8'hD4, 8'h00, 8'd3},  // R3 bank1[60]
    '{1'b0, 1'b1, 8'h02, 8'h00, 8'hD4, 8'd3},
    '{1'b1, 1'b0, 8'h04, 8'h00, 8'h00, 8'd10},
    '{1'b1, 1'b0, 8'h60, 8'h11, 8'h00, 8'd3},  // bank0[60]
    '{1'b0, 1'b1, 8'h02, 8'h00, 8'h11, 8'd3},  // R3 follows BP
    '{1'b1, 1'b0, 8'h04, 8'h01, 8'h00, 8'd10},
    '{1'b0, 1'b1, 8'h60, 8'h00, 8'hD4, 8'd3},
    '{1'b1, 1'b0, 8'h10, 8'h77, 8'h00, 8'd7},  // R7 shared[10], BP=1
    '{1'b1, 1'b0, 8'h03, 8'h10, 8'h00, 8'd10},
    '{1'b1, 1'b0, 8'h04, 8'h02, 8'h00, 8'd10},
    '{1'b0, 1'b1, 8'h02, 8'h00, 8'h77, 8'd7},  // R7 indirect low ignores BP
    '{1'b1, 1'b0, 8'h02, 8'h88, 8'h00, 8'd7},
    '{1'b1, 1'b0, 8'h04, 8'h00, 8'h00, 8'd10},
    '{1'b0, 1'b1, 8'h10, 8'h00, 8'h88, 8'd7},
    '{1'b1, 1'b0, 8'h01, 8'h02, 8'h00, 8'd10}, // MP0=02
    '{1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'd4},  // R4 self-ref read
    '{1'b1, 1'b0, 8'h00, 8'h55, 8'h00, 8'd4},
    '{1'b0, 1'b1, 8'h03, 8'h00, 8'h10, 8'd4},  // R4 MP1 untouched
    '{1'b0, 1'b1, 8'h01, 8'h00, 8'h02, 8'd4},
    '{1'b1, 1'b0, 8'h03, 8'h00, 8'h00, 8'd10}, // MP1=00
    '{1'b0, 1'b1, 8'h02, 8'h00, 8'h00, 8'd4},
    '{1'b1, 1'b0, 8'h02, 8'h99, 8'h00, 8'd4},
    '{1'b0, 1'b1, 8'h01, 8'h00, 8'h02, 8'd4},  // R4 MP0 untouched
    '{1'b1, 1'b0, 8'h04, 8'hFF, 8'h00, 8'd5},
    '{1'b0, 1'b1, 8'h04, 8'h00, 8'h1F, 8'd5},  // R5 truncated
    '{1'b1, 1'b0, 8'h04, 8'h05, 8'h00, 8'd10}, // bank 5 unimplemented
    '{1'b1, 1'b0, 8'h40, 8'hEE, 8'h00, 8'd8},
    '{1'b0, 1'b1, 8'h40, 8'h00, 8'h00, 8'd8},  // R8 reads zero
    '{1'b1, 1'b0, 8'h04, 8'h01, 8'h00, 8'd10},
    '{1'b0, 1'b1, 8'h40, 8'h00, 8'hA1, 8'd8},  // R8 no alias into bank1
    '{1'b0, 1'b0, 8'h40, 8'h00, 8'h00, 8'd9}   // R9 idle strobe reads zero
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic rd, input logic [7:0] a, input logic [7:0] d);
    wr_i = wr; rd_i = rd; addr_i = a; wdata_i = d;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    check(mp0_o, 8'h00, 1, "mp0 in reset");
    check(mp1_o, 8'h00, 1, "mp1 in reset");
    check(8'(bp_o), 8'h00, 1, "bp in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    drive(1'b0, 1'b1, 8'h01, 8'h00);
    #2 check(rdata_o, 8'h00, 1, "mp0 read after reset");

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].wd);
      #2 check(rdata_o, VECS[i].exp, int'(VECS[i].req), $sformatf("vec %0d", i));
    end

    // R10: pointer outputs (MP0=02, MP1=00, BP=1)
    @(negedge clk_i);
    drive(1'b0, 1'b0, 8'h00, 8'h00);
    #2;
    check(mp0_o, 8'h02, 10, "mp0_o");
    check(mp1_o, 8'h00, 10, "mp1_o");
    check(8'(bp_o), 8'h01, 10, "bp_o");

    // R9: write commits only at the edge; same-cycle read shows old value
    drive(1'b1, 1'b1, 8'h20, 8'h3C);
    @(negedge clk_i);
    drive(1'b1, 1'b1, 8'h20, 8'h5A);
    #2 check(rdata_o, 8'h3C, 9, "read before edge");
    @(negedge clk_i);
    drive(1'b0, 1'b1, 8'h20, 8'h00);
    #2 check(rdata_o, 8'h5A, 9, "read after edge");

    // R1: asynchronous reset clears pointers mid-run
    #1 rst_ni = 1'b0;
    #1 check(mp0_o, 8'h00, 1, "mp0 async clear");
    check(8'(bp_o), 8'h00, 1, "bp async clear");
    @(negedge clk_i);
    drive(1'b0, 1'b0, 8'h00, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule